// File: doc/BRIEF.md
# Fixed-Point Audio DSP ALU

This block is the single-cycle execution stage of a 32-bit fixed-point audio effects engine. Each cycle where `valid` is high, it decodes a 4-bit opcode and three signed 32-bit operands `a`, `x` and `y`. It registers a 32-bit result `r` and a nine-bit condition-code word `ccr`. It also updates a wide internal accumulator, which is visible on `acc`.

The operation set covers the following:
- fractional (Q1.31) multiply-accumulate, in plain and negated-product forms;
- integer multiply-accumulate;
- a three-operand add;
- an AND-then-XOR bitwise operation;
- three signed compare-and-select operations;
- linear interpolation between two samples.

Each arithmetic opcode fixes whether it clamps to the signed 32-bit range or wraps. One opcode passes `a` through while it adds a fractional product into the accumulator in the background. The three conversion and branch opcodes are handled elsewhere. Here they simply return `a` and leave every piece of state alone.

Top module: `dsp_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `r`, `ccr` and `acc` to zero.
- R2: Opcode 0x0 gives R = A + floor(X*Y / 2^31), clamped to [0x80000000, 0x7FFFFFFF]. Opcode 0x2 gives the same sum, keeping its low 32 bits.
- R3: Opcode 0x1 gives R = A + floor(-(X*Y) / 2^31), clamped. Opcode 0x3 gives the same sum, keeping its low 32 bits.
- R4: Opcode 0x4 gives R = A + X*Y, clamped. Opcode 0x5 takes the low 31 bits of A + X*Y and sign-extends them from bit 30.
- R5: Opcode 0x6 gives R = A + X + Y, clamped.
- R6: Opcode 0x7 gives R = A and adds floor(X*Y / 2^31) into `acc`. Opcodes 0x0-0x6 and 0xE load `acc` with their exact unclamped sum, sign-extended. Opcodes 0x8-0xD and 0xF leave `acc` unchanged.
- R7: Opcode 0x8 gives R = (A & X) ^ Y.
- R8: All comparisons here are signed.
  - Opcode 0x9 gives R = X when A >= Y, and ~X otherwise.
  - Opcode 0xA gives X when A >= Y, and Y otherwise.
  - Opcode 0xB gives X when A < Y, and Y otherwise.
  - For these three opcodes, borrow (ccr bit 1) equals A < Y. For the other flag-updating opcodes, borrow is 0.
- R9: Opcode 0xE gives R = A + floor(X*(Y-A) / 2^31), clamped.
- R10: After every in-scope opcode, the following flags are written from R; ccr bits 5 to 7 are always 0.
  - bit 2 (minus) = R[31];
  - bit 3 (zero) = (R == 0);
  - bit 8 (nonzero) = (R != 0);
  - bit 0 (normalized) = R[31] XOR R[30].
- R11: Saturate (ccr bit 4) is 1 only when opcode 0x0, 0x1, 0x4, 0x6 or 0xE actually clamps its result. Otherwise it is 0.
- R12: Opcodes 0xC, 0xD and 0xF give R = A and leave `ccr` and `acc` unchanged.
- R13: Results and flags appear on the rising edge after `valid`. While `valid` is low, `r`, `ccr` and `acc` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Execute the presented operation this cycle |
| opcode | input | 4 | Operation select |
| a | input | 32 | Signed operand A |
| x | input | 32 | Signed operand X |
| y | input | 32 | Signed operand Y |
| r | output | 32 | Registered result |
| ccr | output | 9 | Condition-code word |
| acc | output | ACC_W (72) | Internal accumulator |

## Verification
The operand patterns are chosen in pairs, so that each pair separates a clamping opcode from its wrapping twin. The same operands push the sum just past either end of the 32-bit range. With saturation the result is a clamped rail; with wraparound it is an aliased value.

Half-scale products separate the exact floor of a negated product from a simple negation of the positive result. A sum whose bit 30 is set shows the 31-bit sign extension of opcode 0x5. Signed operands of opposite sign show a signed comparison rather than an unsigned one, through both the selected value and the borrow flag.

Accumulator sequences check that a background move adds to the accumulator while other opcodes overwrite it. The pass-through opcodes and idle cycles are checked for leaving both flags and accumulator intact.

// File: rtl/dsp_exec_pkg.sv
package dsp_exec_pkg;

    parameter int DW      = 32;          // sample width
    parameter int SW      = 2*DW + 2;    // exact width for every sum
    parameter int FRAC_SH = DW - 1;      // Q1.31 product alignment
    parameter int CCW     = 9;           // condition-code word width

    localparam int CC_NORM   = 0;
    localparam int CC_BORROW = 1;
    localparam int CC_MINUS  = 2;
    localparam int CC_ZERO   = 3;
    localparam int CC_SAT    = 4;
    localparam int CC_NZ     = 8;

    typedef enum logic [3:0] {
        OP_MACF   = 4'h0,
        OP_MACFN  = 4'h1,
        OP_MACFW  = 4'h2,
        OP_MACFNW = 4'h3,
        OP_MACI   = 4'h4,
        OP_MACIW  = 4'h5,
        OP_ADD3   = 4'h6,
        OP_MOVACC = 4'h7,
        OP_ANDXOR = 4'h8,
        OP_TSTNEG = 4'h9,
        OP_SELGE  = 4'hA,
        OP_SELLT  = 4'hB,
        OP_CVTLOG = 4'hC,
        OP_CVTEXP = 4'hD,
        OP_INTERP = 4'hE,
        OP_SKIP   = 4'hF
    } op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          clamped;
        logic          borrow;
        logic          touch_flags;
        logic          acc_load;
        logic          acc_add;
        logic [SW-1:0] acc_val;
    } alu_out_t;

    localparam logic signed [SW-1:0] SMAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] SMIN = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    // returns {clamped, value}
    function automatic logic [DW:0] clamp(input logic signed [SW-1:0] v);
        if (v > SMAX)      return {1'b1, 1'b0, {(DW-1){1'b1}}};
        else if (v < SMIN) return {1'b1, 1'b1, {(DW-1){1'b0}}};
        else               return {1'b0, v[DW-1:0]};
    endfunction

    function automatic logic [SW-1:0] sext(input logic [DW-1:0] v);
        return {{(SW-DW){v[DW-1]}}, v};
    endfunction

    function automatic logic is_sat_op(input op_e op);
        return (op == OP_MACF) || (op == OP_MACFN) || (op == OP_MACI) ||
               (op == OP_ADD3) || (op == OP_INTERP);
    endfunction

    function automatic logic in_scope(input op_e op);
        return !((op == OP_CVTLOG) || (op == OP_CVTEXP) || (op == OP_SKIP));
    endfunction

endpackage

// File: rtl/dsp_mul_unit.sv
module dsp_mul_unit
    import dsp_exec_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [SW-1:0] int_p,
    output logic [SW-1:0] frac_p,
    output logic [SW-1:0] frac_n,
    output logic [SW-1:0] interp_p
);
    logic signed [SW-1:0] as_w, xs_w, ys_w, prod_w, diff_w, iprod_w;

    assign as_w    = sext(a);
    assign xs_w    = sext(x);
    assign ys_w    = sext(y);
    assign prod_w  = xs_w * ys_w;              // exact, |p| <= 2^62
    assign diff_w  = ys_w - as_w;              // 33 significant bits
    assign iprod_w = xs_w * diff_w;            // exact, |p| <= 2^63

    assign int_p    = prod_w;
    assign frac_p   = prod_w >>> FRAC_SH;      // floor division
    assign frac_n   = (-prod_w) >>> FRAC_SH;
    assign interp_p = iprod_w >>> FRAC_SH;
endmodule

// File: rtl/dsp_arith_unit.sv
module dsp_arith_unit
    import dsp_exec_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [SW-1:0] int_p,
    input  logic [SW-1:0] frac_p,
    input  logic [SW-1:0] frac_n,
    input  logic [SW-1:0] interp_p,
    output alu_out_t      o
);
    logic signed [SW-1:0] as_w, s_frac, s_fracn, s_int, s_add3, s_interp;
    logic                 a_lt_y;

    assign as_w     = sext(a);
    assign s_frac   = as_w + frac_p;
    assign s_fracn  = as_w + frac_n;
    assign s_int    = as_w + int_p;
    assign s_add3   = as_w + sext(x) + sext(y);
    assign s_interp = as_w + interp_p;
    assign a_lt_y   = $signed(a) < $signed(y);

    always_comb begin
        o             = '0;
        o.res         = a;
        o.touch_flags = in_scope(op);
        unique case (op)
            OP_MACF:   begin {o.clamped, o.res} = clamp(s_frac);   o.acc_load = 1'b1; o.acc_val = s_frac;   end
            OP_MACFW:  begin o.res = s_frac[DW-1:0];               o.acc_load = 1'b1; o.acc_val = s_frac;   end
            OP_MACFN:  begin {o.clamped, o.res} = clamp(s_fracn);  o.acc_load = 1'b1; o.acc_val = s_fracn;  end
            OP_MACFNW: begin o.res = s_fracn[DW-1:0];              o.acc_load = 1'b1; o.acc_val = s_fracn;  end
            OP_MACI:   begin {o.clamped, o.res} = clamp(s_int);    o.acc_load = 1'b1; o.acc_val = s_int;    end
            OP_MACIW:  begin o.res = {s_int[DW-2], s_int[DW-2:0]}; o.acc_load = 1'b1; o.acc_val = s_int;    end
            OP_ADD3:   begin {o.clamped, o.res} = clamp(s_add3);   o.acc_load = 1'b1; o.acc_val = s_add3;   end
            OP_INTERP: begin {o.clamped, o.res} = clamp(s_interp); o.acc_load = 1'b1; o.acc_val = s_interp; end
            OP_MOVACC: begin o.res = a; o.acc_add = 1'b1; o.acc_val = frac_p; end
            OP_ANDXOR: o.res = (a & x) ^ y;
            OP_TSTNEG: begin o.res = a_lt_y ? ~x : x; o.borrow = a_lt_y; end
            OP_SELGE:  begin o.res = a_lt_y ? y : x;  o.borrow = a_lt_y; end
            OP_SELLT:  begin o.res = a_lt_y ? x : y;  o.borrow = a_lt_y; end
            default:   o.res = a;
        endcase
    end
endmodule

// File: rtl/dsp_flag_unit.sv
module dsp_flag_unit
    import dsp_exec_pkg::*;
(
    input  alu_out_t       o,
    input  logic [CCW-1:0] ccr_q,
    output logic [CCW-1:0] ccr_d
);
    always_comb begin
        if (!o.touch_flags) begin
            ccr_d = ccr_q;
        end else begin
            ccr_d            = '0;
            ccr_d[CC_NORM]   = o.res[DW-1] ^ o.res[DW-2];
            ccr_d[CC_BORROW] = o.borrow;
            ccr_d[CC_MINUS]  = o.res[DW-1];
            ccr_d[CC_ZERO]   = (o.res == '0);
            ccr_d[CC_SAT]    = o.clamped;
            ccr_d[CC_NZ]     = (o.res != '0);
        end
    end
endmodule

// File: rtl/dsp_exec_unit.sv
module dsp_exec_unit
    import dsp_exec_pkg::*;
#(
    parameter int ACC_W = 72
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [3:0]       opcode,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    x,
    input  logic [DW-1:0]    y,
    output logic [DW-1:0]    r,
    output logic [CCW-1:0]   ccr,
    output logic [ACC_W-1:0] acc
);
    op_e             op;
    logic [SW-1:0]   int_p, frac_p, frac_n, interp_p;
    alu_out_t        alu_o;
    logic [CCW-1:0]  ccr_q, ccr_d;
    logic [DW-1:0]   r_q;
    logic [ACC_W-1:0] acc_q, acc_ext;

    assign op = op_e'(opcode);

    dsp_mul_unit u_mul (
        .a(a), .x(x), .y(y),
        .int_p(int_p), .frac_p(frac_p), .frac_n(frac_n), .interp_p(interp_p)
    );

    dsp_arith_unit u_arith (
        .op(op), .a(a), .x(x), .y(y),
        .int_p(int_p), .frac_p(frac_p), .frac_n(frac_n), .interp_p(interp_p),
        .o(alu_o)
    );

    dsp_flag_unit u_flags (
        .o(alu_o), .ccr_q(ccr_q), .ccr_d(ccr_d)
    );

    generate
        if (ACC_W > SW) begin : g_acc_wide
            assign acc_ext = {{(ACC_W-SW){alu_o.acc_val[SW-1]}}, alu_o.acc_val};
        end else if (ACC_W == SW) begin : g_acc_same
            assign acc_ext = alu_o.acc_val;
        end else begin : g_acc_narrow
            assign acc_ext = alu_o.acc_val[ACC_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q   <= '0;
            ccr_q <= '0;
            acc_q <= '0;
        end else if (valid) begin
            r_q   <= alu_o.res;
            ccr_q <= ccr_d;
            if (alu_o.acc_load)     acc_q <= acc_ext;
            else if (alu_o.acc_add) acc_q <= acc_q + acc_ext;
        end
    end

    assign r   = r_q;
    assign ccr = ccr_q;
    assign acc = acc_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(r_q) && $stable(ccr_q) && $stable(acc_q))); // R13

    AST_OOS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (valid && !in_scope(op)) |=> ($stable(ccr_q) && $stable(acc_q) && r_q == $past(a))); // R12

    AST_SAT_ONLY_CLAMPING: assert property (@(posedge clk) disable iff (rst)
        (valid && in_scope(op) && !is_sat_op(op)) |=> !ccr_q[CC_SAT]); // R11

    AST_ZERO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (valid && in_scope(op)) |=> (ccr_q[CC_ZERO] == (r_q == '0) && ccr_q[CC_NZ] == (r_q != '0))); // R10

    AST_MOVE_PASSES_A: assert property (@(posedge clk) disable iff (rst)
        (valid && op == OP_MOVACC) |=> (r_q == $past(a))); // R6
endmodule

// File: tb/test_dsp_exec_unit.sv
`timescale 1ns/1ps
module test_dsp_exec_unit;
    localparam int AW = 72;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] r;
        logic [8:0]  cc;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 32'h10000000, 32'h40000000, 32'h40000000, 32'h30000000, 9'h100}, // R2
        '{4'h0, 32'h70000000, 32'h40000000, 32'h40000000, 32'h7FFFFFFF, 9'h111}, // R2 R11
        '{4'h2, 32'h70000000, 32'h40000000, 32'h40000000, 32'h90000000, 9'h105}, // R2
        '{4'h1, 32'h10000000, 32'h40000000, 32'h40000000, 32'hF0000000, 9'h104}, // R3
        '{4'h3, 32'h80000000, 32'h40000000, 32'h40000000, 32'h60000000, 9'h101}, // R3
        '{4'h1, 32'h80000000, 32'h40000000, 32'h40000000, 32'h80000000, 9'h115}, // R3 R11
        '{4'h4, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 32'hFFFFFFFF, 9'h104}, // R4
        '{4'h4, 32'h00000000, 32'h00010000, 32'h00010000, 32'h7FFFFFFF, 9'h111}, // R4
        '{4'h5, 32'h00000000, 32'h00010000, 32'h00010000, 32'h00000000, 9'h008}, // R4 R10
        '{4'h5, 32'h40000000, 32'h00000000, 32'h00000000, 32'hC0000000, 9'h104}, // R4
        '{4'h6, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 32'h7FFFFFFF, 9'h111}, // R5
        '{4'h6, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000006, 9'h100}, // R5
        '{4'h6, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 9'h115}, // R5
        '{4'h8, 32'hFF00FF00, 32'h0F0F0F0F, 32'h000000FF, 32'h0F000FFF, 9'h100}, // R7
        '{4'h9, 32'hFFFFFFFF, 32'h12345678, 32'h00000001, 32'hEDCBA987, 9'h106}, // R8
        '{4'h9, 32'h00000003, 32'h0000000F, 32'h00000003, 32'h0000000F, 9'h100}, // R8
        '{4'hA, 32'h00000005, 32'h00000007, 32'h00000005, 32'h00000007, 9'h100}, // R8
        '{4'hA, 32'h80000000, 32'h00000007, 32'h00000003, 32'h00000003, 9'h102}, // R8
        '{4'hB, 32'h80000000, 32'h00000007, 32'h00000003, 32'h00000007, 9'h102}, // R8
        '{4'hE, 32'h10000000, 32'h40000000, 32'h30000000, 32'h20000000, 9'h100}, // R9
        '{4'hE, 32'h7FFFFFFF, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 9'h111}  // R9 R11
    };

    logic          clk = 1'b0;
    logic          rst, valid;
    logic [3:0]    opcode;
    logic [31:0]   a, x, y, r;
    logic [8:0]    ccr;
    logic [AW-1:0] acc;
    int            n_cmp = 0;
    int            n_bad = 0;

    always #2 clk = ~clk;

    dsp_exec_unit #(.ACC_W(AW)) i_dsp_exec_unit (
        .clk(clk), .rst(rst), .valid(valid), .opcode(opcode),
        .a(a), .x(x), .y(y), .r(r), .ccr(ccr), .acc(acc)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] ia, input logic [31:0] ix,
                       input logic [31:0] iy);
        @(negedge clk);
        opcode = op; a = ia; x = ix; y = iy; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; valid = 1'b0; opcode = '0; a = '0; x = '0; y = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset r", AW'(r), '0);
        chk("R1 reset ccr", AW'(ccr), '0);
        chk("R1 reset acc", acc, '0);

        // R2 R3 R4 R5 R7 R8 R9 R10 R11: vector table
        for (int i = 0; i < NV; i++) begin
            run(VEC[i].op, VEC[i].a, VEC[i].x, VEC[i].y);
            chk($sformatf("vec%0d op%0h r", i, VEC[i].op), AW'(r), AW'(VEC[i].r));
            chk($sformatf("vec%0d op%0h ccr R10", i, VEC[i].op), AW'(ccr), AW'(VEC[i].cc));
        end

        // R6: accumulator load and background add
        run(4'h0, 32'h10000000, 32'h40000000, 32'h40000000);
        chk("R6 load by op0", acc, 72'h30000000);
        run(4'h7, 32'h11111111, 32'h40000000, 32'h40000000);
        chk("R6 move r", AW'(r), 72'h11111111);
        chk("R6 move acc add", acc, 72'h50000000);
        chk("R6 move ccr", AW'(ccr), 72'h100);
        run(4'h7, 32'h00000000, 32'h40000000, 32'hC0000000);
        chk("R6 move acc add negative", acc, 72'h30000000);
        run(4'h1, 32'h10000000, 32'h40000000, 32'h40000000);
        chk("R6 load negative", acc, 72'hFFFFFFFFFFF0000000);
        run(4'h5, 32'h00000000, 32'h00010000, 32'h00010000);
        chk("R6 load unclamped int", acc, 72'h100000000);
        run(4'h8, 32'h0, 32'h0, 32'h0);
        chk("R6 logic op keeps acc", acc, 72'h100000000);

        // R12: pass-through opcodes keep flags and acc
        run(4'h6, 32'h7FFFFFFF, 32'h00000001, 32'h00000000);
        chk("R12 setup ccr", AW'(ccr), 72'h111);
        chk("R12 setup acc", acc, 72'h80000000);
        run(4'hC, 32'h00002222, 32'h5, 32'h6);
        chk("R12 opC r", AW'(r), 72'h2222);
        chk("R12 opC ccr", AW'(ccr), 72'h111);
        chk("R12 opC acc", acc, 72'h80000000);
        run(4'hD, 32'h00000000, 32'h5, 32'h6);
        chk("R12 opD r", AW'(r), 72'h0);
        chk("R12 opD ccr", AW'(ccr), 72'h111);
        run(4'hF, 32'h80000001, 32'h40000000, 32'h40000000);
        chk("R12 opF r", AW'(r), 72'h80000001);
        chk("R12 opF ccr", AW'(ccr), 72'h111);
        chk("R12 opF acc", acc, 72'h80000000);

        // R13: idle cycles hold everything
        @(negedge clk);
        opcode = 4'h0; a = 32'h12345678; x = 32'h40000000; y = 32'h40000000; valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 idle r", AW'(r), 72'h80000001);
        chk("R13 idle ccr", AW'(ccr), 72'h111);
        chk("R13 idle acc", acc, 72'h80000000);

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset r", AW'(r), '0);
        chk("R1 mid reset ccr", AW'(ccr), '0);
        chk("R1 mid reset acc", acc, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule